// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive side of a packet DMA engine. It walks a ring of two-word descriptors kept in memory and reached through a simple single-port memory interface. When a frame starts on the incoming byte stream, the block reads the current descriptor and checks that software has handed it over. It then packs the frame bytes into 32-bit words and writes them into that descriptor's buffer. When the frame ends, or the buffer fills, it writes the status word and then sets the descriptor's used bit.

A frame longer than one buffer continues into the descriptors that follow. The first descriptor of a frame carries the start flag and the last one carries the end flag and the total length. If a descriptor is still owned by software, the block drops the rest of the frame and pulses an overflow output. The ring position stays on the refused descriptor. Descriptor word 0 holds the buffer address in bits 31:2, the used bit in bit 0 and the last-in-ring (wrap) bit in bit 1. Descriptor word 1 is the status word. Software arms a descriptor by writing a status of 0xF0000000 and clearing the used bit.

Top module: `rxring_writer`

## Requirements
- R1: On a byte with the start flag while idle, the block first issues a memory read of descriptor word 0 at ring_base + 8 * index, and accepts no frame byte before that read; the index is 0 after reset.
- R2: Frame bytes are stored little-endian (byte k of a word in bits 8k+7:8k) at (word0 & 0xFFFFFFFC) + offset, as 32-bit word writes whose byte enables mark exactly the bytes written.
- R3: The status word, written to descriptor address + 4, has bit 14 set only on the first descriptor of a frame, bit 15 set only on the last, bits 13:0 equal to the total frame length on the last descriptor and 0 on the others, and all other bits 0.
- R4: Handing a descriptor back rewrites word 0 with the address and bit 1 preserved and bit 0 set; rx_done pulses for one cycle in the same cycle as the hand-back of a frame's last descriptor.
- R5: A frame longer than BUF_BYTES fills its buffer, hands that descriptor back, and continues in the next descriptor of the ring.
- R6: After a descriptor whose bit 1 is set is handed back, the next descriptor used is the one at ring_base; otherwise it is the next one at +8 bytes, and the index also returns to 0 after MAX_RING descriptors.
- R7: If the descriptor read at frame start has bit 0 set, rx_ovf pulses, the whole frame is consumed and discarded with no memory write, and the next frame uses the same descriptor.
- R8: If a continuation descriptor has bit 0 set, rx_ovf pulses, the rest of the frame is discarded, the descriptors already filled stay handed back, rx_done does not pulse, and the next frame starts at the refused descriptor.
- R9: The status word of a descriptor is written in the cycle immediately before its word 0 with bit 0 set.
- R10: Bytes that arrive while idle without the start flag are consumed and discarded with no memory access.
- R11: A frame whose end flag falls on the last byte of a buffer is closed in that descriptor, and no further descriptor is read.
- R12: After reset no memory request, rx_done or rx_ovf is active, and in_ready is high while no start flag is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 32 | Byte address of descriptor 0 of the ring |
| in_valid | input | 1 | Byte on in_data is valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Block accepts the byte this cycle |
| mem_req | output | 1 | Memory access request, one per cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_done | output | 1 | One-cycle pulse when a frame has been handed back |
| rx_ovf | output | 1 | One-cycle pulse when a frame is dropped for lack of a free descriptor |

## Verification
The bench builds the block with BUF_BYTES = 16 and MAX_RING = 4, with a ring_base that is not zero. These values let frames of 20 bytes span two buffers and let the wrap bit be reached within four frames. They also make a busy descriptor easy to arrange, both at the start of a frame and in the middle of one. The case where the end flag lands exactly on a buffer boundary needs only a 16-byte frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int OWN_POS   = 0;
  localparam int WRAP_POS  = 1;
  localparam int FIRST_POS = 14;
  localparam int LAST_POS  = 15;
  localparam int LEN_BITS  = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_FILL,
    ST_STAT,
    ST_OWN,
    ST_SKIP
  } rxr_state_e;

  function automatic logic [31:0] rxr_status(input logic first,
                                             input logic last,
                                             input logic [LEN_BITS-1:0] len);
    logic [31:0] s;
    s = '0;
    s[LEN_BITS-1:0] = len;
    s[FIRST_POS] = first;
    s[LAST_POS] = last;
    return s;
  endfunction
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int MAX_RING = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance,
  input  logic        wrap,
  input  logic [31:0] base,
  output logic [31:0] desc_addr
);
  localparam int IDX_W = (MAX_RING > 1) ? $clog2(MAX_RING) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_RING - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_n;

  always_comb begin
    idx_n = idx_q;
    if (advance) begin
      if (wrap || (idx_q == IDX_LAST)) idx_n = '0;
      else                             idx_n = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_n;
  end

  assign desc_addr = base + {{(29-IDX_W){1'b0}}, idx_q, 3'b000};
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  input  logic        flush,
  output logic [31:0] word_o,
  output logic [3:0]  be_o
);
  logic [31:0] acc_q, acc_n;
  logic [3:0]  be_q, be_n;

  always_comb begin
    word_o = acc_q;
    be_o   = be_q;
    if (take) begin
      word_o[{lane, 3'b000} +: 8] = din;
      be_o[lane] = 1'b1;
    end
  end

  always_comb begin
    acc_n = word_o;
    be_n  = be_o;
    if (flush) begin
      acc_n = '0;
      be_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      be_q  <= '0;
    end else if (take) begin
      acc_q <= acc_n;
      be_q  <= be_n;
    end
  end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        in_ready,
  input  logic [31:0] desc_addr,
  output logic        adv,
  output logic        wrap_o,
  output logic        pk_take,
  output logic [1:0]  pk_lane,
  output logic        pk_flush,
  input  logic [31:0] pk_word,
  input  logic [3:0]  pk_be,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        rx_done,
  output logic        rx_ovf
);
  localparam int OFF_W = $clog2(BUF_BYTES);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BUF_BYTES - 1);

  rxr_state_e          st_q, st_n;
  logic [31:0]         desc_q, desc_n;
  logic [OFF_W-1:0]    off_q, off_n;
  logic [LEN_BITS-1:0] flen_q, flen_n;
  logic                first_q, first_n;
  logic                last_q, last_n;
  logic                take;
  logic [31:0]         buf_base;

  assign take     = in_valid && in_ready;
  assign buf_base = desc_q & 32'hFFFF_FFFC;
  assign wrap_o   = desc_q[WRAP_POS];
  assign pk_lane  = off_q[1:0];

  always_comb begin
    st_n      = st_q;
    desc_n    = desc_q;
    off_n     = off_q;
    flen_n    = flen_q;
    first_n   = first_q;
    last_n    = last_q;
    in_ready  = 1'b0;
    adv       = 1'b0;
    pk_take   = 1'b0;
    pk_flush  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_be    = 4'h0;
    mem_wdata = '0;
    rx_done   = 1'b0;
    rx_ovf    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        in_ready = !in_sof;
        first_n  = 1'b1;
        last_n   = 1'b0;
        flen_n   = '0;
        if (in_valid && in_sof) st_n = ST_RDREQ;
      end
      ST_RDREQ: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr;
        st_n     = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (mem_rdata[OWN_POS]) begin
          rx_ovf = 1'b1;
          st_n   = ST_SKIP;
        end else begin
          desc_n = mem_rdata;
          off_n  = '0;
          st_n   = ST_FILL;
        end
      end
      ST_FILL: begin
        in_ready = 1'b1;
        if (take) begin
          pk_take  = 1'b1;
          pk_flush = (off_q[1:0] == 2'd3) || in_eof || (off_q == OFF_LAST);
          if (pk_flush) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_base + (32'(off_q) & 32'hFFFF_FFFC);
            mem_be    = pk_be;
            mem_wdata = pk_word;
          end
          off_n  = off_q + 1'b1;
          flen_n = flen_q + 1'b1;
          if (in_eof) begin
            last_n = 1'b1;
            st_n   = ST_STAT;
          end else if (off_q == OFF_LAST) begin
            last_n = 1'b0;
            st_n   = ST_STAT;
          end
        end
      end
      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr + 32'd4;
        mem_be    = 4'hF;
        mem_wdata = rxr_status(first_q, last_q, last_q ? flen_q : '0);
        st_n      = ST_OWN;
      end
      ST_OWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr;
        mem_be    = 4'hF;
        mem_wdata = desc_q | 32'h1;
        adv       = 1'b1;
        if (last_q) begin
          rx_done = 1'b1;
          st_n    = ST_IDLE;
        end else begin
          first_n = 1'b0;
          st_n    = ST_RDREQ;
        end
      end
      ST_SKIP: begin
        in_ready = 1'b1;
        if (take && in_eof) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      desc_q  <= '0;
      off_q   <= '0;
      flen_q  <= '0;
      first_q <= 1'b1;
      last_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      desc_q  <= desc_n;
      off_q   <= off_n;
      flen_q  <= flen_n;
      first_q <= first_n;
      last_q  <= last_n;
    end
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
  parameter int BUF_BYTES = 1536,
  parameter int MAX_RING  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        in_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        rx_done,
  output logic        rx_ovf
);
  logic [31:0] desc_addr;
  logic        adv;
  logic        wrap;
  logic        pk_take;
  logic [1:0]  pk_lane;
  logic        pk_flush;
  logic [31:0] pk_word;
  logic [3:0]  pk_be;

  rxr_ring_ptr #(.MAX_RING(MAX_RING)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (adv),
    .wrap      (wrap),
    .base      (ring_base),
    .desc_addr (desc_addr)
  );

  rxr_pack u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (pk_take),
    .lane   (pk_lane),
    .din    (in_data),
    .flush  (pk_flush),
    .word_o (pk_word),
    .be_o   (pk_be)
  );

  rxr_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_ready  (in_ready),
    .desc_addr (desc_addr),
    .adv       (adv),
    .wrap_o    (wrap),
    .pk_take   (pk_take),
    .pk_lane   (pk_lane),
    .pk_flush  (pk_flush),
    .pk_word   (pk_word),
    .pk_be     (pk_be),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .rx_done   (rx_done),
    .rx_ovf    (rx_ovf)
  );
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        rx_done,
  input logic        rx_ovf,
  input logic [31:0] desc_addr
);
  // R1
  desc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == desc_addr && !in_ready));

  // R2
  write_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'h0));

  // R3
  status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr == desc_addr + 32'd4) |-> (mem_wdata[31:16] == 16'h0));

  // R4
  done_handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (mem_req && mem_we && mem_wdata[0] && mem_addr == desc_addr));

  // R7
  ovf_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> (!mem_req && !rx_done));

  // R7
  ovf_hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> $stable(desc_addr));

  // R9
  status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wdata[0] && mem_addr == desc_addr)
      |-> ($past(mem_req) && $past(mem_we) && $past(mem_addr) == mem_addr + 32'd4));
endmodule

bind rxring_writer rxring_writer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .rx_done   (rx_done),
  .rx_ovf    (rx_ovf),
  .desc_addr (desc_addr)
);

// File: tb/tb_rxring_writer.sv
`timescale 1ns/1ps
module tb_rxring_writer;
  localparam int BUFB = 16;
  localparam int RING = 4;
  localparam logic [31:0] BASE = 32'h40;
  localparam logic [31:0] BUF0 = 32'h100;

  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        rx_done, rx_ovf;

  logic [31:0] mem [0:127];
  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  int ovf_cnt = 0;
  logic [31:0] last_rd_addr = 32'hFFFF_FFFF;
  logic        prev_we = 1'b0;
  logic [31:0] prev_addr = 32'h0;

  rxring_writer #(.BUF_BYTES(BUFB), .MAX_RING(RING)) dut (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_done(rx_done), .rx_ovf(rx_ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // memory model and monitors
  always @(posedge clk) begin
    if (mem_req && !mem_we) begin
      mem_rdata <= mem[mem_addr[8:2]];
      last_rd_addr <= mem_addr;
    end
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[8:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      wr_cnt++;
      if (mem_wdata[0] && mem_addr >= BASE && mem_addr < BASE + 32 && mem_addr[2:0] == 3'b000)
        chk(prev_we && prev_addr == mem_addr + 4, "R9 status before used bit", prev_addr, mem_addr + 4);
    end
    prev_we   <= mem_req && mem_we;
    prev_addr <= mem_addr;
    if (rx_done) done_cnt++;
    if (rx_ovf)  ovf_cnt++;
  end

  function automatic logic [31:0] dw(input int i, input int w);
    return mem[(BASE[8:2]) + 2*i + w];
  endfunction

  task automatic arm(input int i);
    mem[BASE[8:2] + 2*i]     = (BUF0 + 16*i) | ((i == RING-1) ? 32'h2 : 32'h0);
    mem[BASE[8:2] + 2*i + 1] = 32'hF000_0000;
  endtask

  task automatic put_byte(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic send(input int n, input logic [7:0] seed, input logic with_sof);
    for (int k = 0; k < n; k++)
      put_byte(seed + 8'(k), with_sof && (k == 0), k == n-1);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic check_buf(input logic [31:0] addr, input logic [7:0] seed, input int n, input string tag);
    bit ok = 1'b1;
    logic [7:0] act = 0, exp = 0;
    for (int k = 0; k < n; k++) begin
      logic [31:0] a;
      a = addr + 32'(k);
      if (mem[a[8:2]][8*a[1:0] +: 8] != seed + 8'(k) && ok) begin
        ok = 1'b0;
        act = mem[a[8:2]][8*a[1:0] +: 8];
        exp = seed + 8'(k);
      end
    end
    chk(ok, tag, {24'h0, act}, {24'h0, exp});
  endtask

  task automatic t_reset();
    #1;
    chk(!mem_req, "R12 no request after reset", {31'h0, mem_req}, 0);
    chk(!rx_done && !rx_ovf, "R12 no pulses after reset", {30'h0, rx_done, rx_ovf}, 0);
    chk(in_ready, "R12 ready while idle", {31'h0, in_ready}, 1);
  endtask

  task automatic t_single();
    int d0 = done_cnt;
    send(6, 8'h10, 1'b1);
    settle();
    chk(last_rd_addr == BASE, "R1 first descriptor read at base", last_rd_addr, BASE);
    check_buf(BUF0, 8'h10, 6, "R2 frame bytes in buffer 0");
    chk(dw(0,1) == 32'h0000_C006, "R3 single status", dw(0,1), 32'h0000_C006);
    chk(dw(0,0) == 32'h0000_0101, "R4 descriptor 0 handed back", dw(0,0), 32'h101);
    chk(done_cnt == d0 + 1, "R4 one done pulse", done_cnt, d0 + 1);
  endtask

  task automatic t_span();
    int d0 = done_cnt;
    send(20, 8'h40, 1'b1);
    settle();
    check_buf(BUF0 + 16, 8'h40, 16, "R5 first segment bytes");
    check_buf(BUF0 + 32, 8'h50, 4, "R5 second segment bytes");
    chk(dw(1,1) == 32'h0000_4000, "R3 first segment status", dw(1,1), 32'h4000);
    chk(dw(2,1) == 32'h0000_8014, "R3 last segment status", dw(2,1), 32'h8014);
    chk(dw(1,0) == 32'h111 && dw(2,0) == 32'h121, "R5 both handed back", dw(2,0), 32'h121);
    chk(done_cnt == d0 + 1, "R5 single done for spanning frame", done_cnt, d0 + 1);
  endtask

  task automatic t_exact();
    int rd = 0;
    send(16, 8'h80, 1'b1);
    settle();
    rd = wr_cnt;
    check_buf(BUF0 + 48, 8'h80, 16, "R11 full buffer bytes");
    chk(dw(3,1) == 32'h0000_C010, "R11 closed in one descriptor", dw(3,1), 32'hC010);
    chk(dw(3,0) == 32'h133, "R4 wrap bit kept on hand-back", dw(3,0), 32'h133);
    chk(last_rd_addr == BASE + 24, "R11 no extra descriptor read", last_rd_addr, BASE + 24);
    chk(wr_cnt == rd, "R11 idle after close", wr_cnt, rd);
  endtask

  task automatic t_wrap();
    arm(0);
    send(4, 8'hA0, 1'b1);
    settle();
    chk(dw(0,1) == 32'h0000_C004, "R6 wrapped frame lands at ring base", dw(0,1), 32'hC004);
    check_buf(BUF0, 8'hA0, 4, "R6 wrapped frame bytes");
  endtask

  task automatic t_busy_start();
    int w0 = wr_cnt, o0 = ovf_cnt, d0 = done_cnt;
    send(6, 8'hC0, 1'b1);
    settle();
    chk(ovf_cnt == o0 + 1, "R7 overflow pulse", ovf_cnt, o0 + 1);
    chk(wr_cnt == w0, "R7 no memory write", wr_cnt, w0);
    chk(done_cnt == d0, "R7 no done", done_cnt, d0);
    chk(dw(1,1) == 32'h0000_4000, "R7 busy descriptor untouched", dw(1,1), 32'h4000);
    arm(1);
    send(5, 8'hD0, 1'b1);
    settle();
    chk(dw(1,1) == 32'h0000_C005, "R7 pointer held on refused descriptor", dw(1,1), 32'hC005);
  endtask

  task automatic t_busy_mid();
    int o0 = ovf_cnt, d0 = done_cnt;
    arm(2);
    send(20, 8'h20, 1'b1);
    settle();
    chk(ovf_cnt == o0 + 1, "R8 overflow mid frame", ovf_cnt, o0 + 1);
    chk(done_cnt == d0, "R8 no done mid frame", done_cnt, d0);
    chk(dw(2,1) == 32'h0000_4000 && dw(2,0) == 32'h121, "R8 filled descriptor handed back", dw(2,1), 32'h4000);
    check_buf(BUF0 + 32, 8'h20, 16, "R8 filled segment bytes");
    arm(3);
    send(3, 8'hE0, 1'b1);
    settle();
    chk(dw(3,1) == 32'h0000_C003, "R8 next frame at refused descriptor", dw(3,1), 32'hC003);
  endtask

  task automatic t_stray();
    int w0 = wr_cnt, d0 = done_cnt;
    send(3, 8'h55, 1'b0);
    settle();
    chk(wr_cnt == w0 && done_cnt == d0, "R10 stray bytes ignored", wr_cnt, w0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    for (int i = 0; i < RING; i++) arm(i);
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_span();
    t_exact();
    t_wrap();
    t_busy_start();
    t_busy_mid();
    t_stray();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule